// File: doc/BRIEF.md
# PECI host bit transceiver

This block is the host-side bit layer for a single-wire bus. On this bus every bit period starts with a rising edge, and the share of the period spent high tells whether the bit is a one or a zero. A message starts when a byte is offered while the block is idle. The block then holds the wire low for a lead-in interval and drives one timing-negotiation pulse. After that it sends the offered bytes most-significant bit first, taking each byte through a valid/ready handshake. At the end it waits for the bus to go quiet.

A byte can be marked as a read byte. In its eight slots the host drives only the short high time of a zero, and the client may stretch the high time to signal a one. The block decodes each such slot by counting how many cycles the wire was high and comparing the count with half the bit period. It returns the decoded byte on a one-cycle strobe.

The bit period is given in clock cycles. It is clamped to a legal range and frozen for the whole message when the message starts. The wire is modelled as two signals. `bus_out` is the level the host drives. `bus_in` is the resolved wire, already synchronous to `clk`, which the host reads back.

Top module: `peci_bit_xcvr`

## Requirements
- R1: In a data slot the host drives `bus_out` high for P - floor(P/4) cycles for a one, or floor(P/4) cycles for a zero, and then low. Each slot lasts exactly P cycles. Here P is the effective bit period.
- R2: A message is, in order: the lead-in, then one negotiation slot with floor(P/2) high cycles, then 8 slots per accepted byte, sent MSB first.
- R3: The lead-in holds `bus_out` low while `busy` is high. The first message after reset uses a lead-in of FIRST_LEAD cycles. Every later message uses 2*P cycles.
- R4: P is `bit_period` clamped to the range [PMIN, PMAX]. It is captured when the message starts. Changes to `bit_period` during a message have no effect on slot lengths.
- R5: `tx_ready` is high only in the last cycle of the negotiation slot, or of the last slot of a byte. A byte is taken when `tx_valid` and `tx_ready` are both high. If `tx_valid` is low at that point, no further slots are sent. A message starts when `tx_valid` is high while the block is idle; that byte is not consumed until the end of the negotiation slot.
- R6: In the slots of a byte taken with `tx_read`=1, the host drives floor(P/4) high cycles. A slot decodes to 1 exactly when `bus_in` was high for more than floor(P/2) of its P cycles. `rx_valid` pulses for one cycle, in the cycle after the byte's last slot, with `rx_data` holding the eight decoded bits, first slot in bit 7.
- R7: `busy` rises in the first lead-in cycle. After the last slot, `busy` stays high until 2*P consecutive cycles pass with no rising edge on `bus_in`. A rising edge restarts that count. So with a quiet bus, `busy` falls 3*P cycles after the last slot's rising edge.
- R8: Asserting `rst_n` low forces `bus_out`, `busy`, `tx_ready` and `rx_valid` low at once and aborts any message. The next message uses the FIRST_LEAD lead-in. `bus_out` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_period | input | PW | Requested bit period in clock cycles |
| tx_valid | input | 1 | Byte offered; also starts a message when idle |
| tx_data | input | 8 | Byte to send |
| tx_read | input | 1 | Byte is a read byte: client drives its value |
| tx_ready | output | 1 | Byte is taken this cycle if tx_valid is high |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a decoded read byte |
| rx_data | output | 8 | Decoded read byte |
| bus_in | input | 1 | Resolved wire level, synchronous to clk |
| bus_out | output | 1 | Level driven by the host |
| busy | output | 1 | Message in progress, from lead-in to stop detection |

## Verification
The bench rebuilds the expected pulse train from each message's bytes and period. It then compares every high time, every gap between rising edges, the lead-in length and the tail after the last slot. An encoder that swapped bit order or rounded the quarter period wrongly shows up as a wrong high time. A period that followed `bit_period` during the message shows up as an uneven edge gap. The client model holds the wire high for exactly floor(P/2) or floor(P/2)+1 cycles, so a decoder using the wrong comparison or dropping the last cycle of a slot returns a wrong byte. Further directed cases cover: a message with no bytes; a clamped period at both ends; a client rising edge during the quiet window, where a design that ignored it would drop `busy` too early; and a reset in the middle of a message, after which the long first lead-in must return.

// File: rtl/peci_pkg.sv
`timescale 1ns/1ps
package peci_pkg;
  localparam int BYTE_W = 8;
  localparam int BIW    = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_NEG,
    ST_BITS,
    ST_STOP
  } xst_e;

  function automatic int fmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/peci_rst_sync.sv
`timescale 1ns/1ps
module peci_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;
endmodule

// File: rtl/peci_bit_timer.sv
`timescale 1ns/1ps
module peci_bit_timer #(
  parameter int PW = 18
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          run,
  input  logic [PW-1:0] per,
  input  logic [PW-1:0] hi_len,
  output logic          level,
  output logic          bit_end
);
  logic [PW-1:0] pc_q, pc_d;

  assign bit_end = run && (pc_q == per - 1'b1);
  assign level   = run && (pc_q < hi_len);

  always_comb begin
    if (!run)         pc_d = '0;
    else if (bit_end) pc_d = '0;
    else              pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  AST_PC_BOUND: assert property (@(posedge clk) disable iff (!rst_sn)
    run |-> (pc_q < per)); // R1
  AST_SLOT_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_sn)
    (run && bit_end) |=> (!run || level)); // R1
endmodule

// File: rtl/peci_rx_sampler.sv
`timescale 1ns/1ps
module peci_rx_sampler #(
  parameter int PW = 18
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          run,
  input  logic          bit_end,
  input  logic [PW-1:0] per,
  input  logic          bus_in,
  output logic          bit_val
);
  logic [PW-1:0] hc_q, hc_d, hc_now;

  assign hc_now  = hc_q + {{(PW-1){1'b0}}, bus_in};
  assign bit_val = hc_now > (per >> 1);

  always_comb begin
    if (!run || bit_end) hc_d = '0;
    else                 hc_d = hc_now;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) hc_q <= '0;
    else         hc_q <= hc_d;
  end

  AST_HC_BOUND: assert property (@(posedge clk) disable iff (!rst_sn)
    run |-> (hc_q < per)); // R6
endmodule

// File: rtl/peci_stop_det.sv
`timescale 1ns/1ps
module peci_stop_det #(
  parameter int LW = 19
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          arm,
  input  logic [LW-1:0] win,
  input  logic          bus_in,
  output logic          done
);
  logic          bus_q;
  logic          rise;
  logic [LW-1:0] cnt_q, cnt_d;

  assign rise = bus_in && !bus_q;
  assign done = arm && !rise && (cnt_q == win - 1'b1);

  always_comb begin
    if (!arm || rise) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      bus_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      bus_q <= bus_in;
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_sn)
    arm |-> (cnt_q < win)); // R7
endmodule

// File: rtl/peci_bit_xcvr.sv
`timescale 1ns/1ps
module peci_bit_xcvr
  import peci_pkg::*;
#(
  parameter int PW         = 18,
  parameter int PMIN       = 99,
  parameter int PMAX       = 100000,
  parameter int FIRST_LEAD = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     bit_period,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_read,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              bus_in,
  output logic              bus_out,
  output logic              busy
);
  localparam int LW = fmax($clog2(FIRST_LEAD + 1), PW + 1);
  localparam logic [PW-1:0] PMIN_V = PW'(PMIN);
  localparam logic [PW-1:0] PMAX_V = PW'(PMAX);

  logic rst_sn;

  xst_e              state_q, state_d;
  logic [PW-1:0]     per_q, per_d, eff_per, hi_len;
  logic              first_q, first_d;
  logic [LW-1:0]     lead_q, lead_d, lead_len, stop_win;
  logic [BIW-1:0]    bidx_q, bidx_d;
  logic [BYTE_W-1:0] txsh_q, txsh_d, rxsh_q, rxsh_d, rxd_q, rxd_d;
  logic              rd_q, rd_d, rxv_q, rxv_d;
  logic              run, bit_end, bit_val, stop_done, last_slot, take;

  peci_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  always_comb begin
    if (bit_period < PMIN_V)      eff_per = PMIN_V;
    else if (bit_period > PMAX_V) eff_per = PMAX_V;
    else                          eff_per = bit_period;
  end

  assign run       = (state_q == ST_NEG) || (state_q == ST_BITS);
  assign lead_len  = first_q ? LW'(FIRST_LEAD) : LW'({per_q, 1'b0});
  assign stop_win  = LW'({per_q, 1'b0});
  assign last_slot = (state_q == ST_NEG) || ((state_q == ST_BITS) && (bidx_q == '0));
  assign tx_ready  = bit_end && last_slot;
  assign take      = tx_ready && tx_valid;

  always_comb begin
    if (state_q == ST_NEG)            hi_len = per_q >> 1;
    else if (rd_q || !txsh_q[BYTE_W-1]) hi_len = per_q >> 2;
    else                              hi_len = per_q - (per_q >> 2);
  end

  peci_bit_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_sn(rst_sn), .run(run), .per(per_q), .hi_len(hi_len),
    .level(bus_out), .bit_end(bit_end));

  peci_rx_sampler #(.PW(PW)) u_rx (
    .clk(clk), .rst_sn(rst_sn), .run(run), .bit_end(bit_end), .per(per_q),
    .bus_in(bus_in), .bit_val(bit_val));

  peci_stop_det #(.LW(LW)) u_stop (
    .clk(clk), .rst_sn(rst_sn), .arm(state_q == ST_STOP), .win(stop_win),
    .bus_in(bus_in), .done(stop_done));

  always_comb begin
    state_d = state_q;
    per_d   = per_q;
    first_d = first_q;
    lead_d  = (state_q == ST_LEAD) ? lead_q + 1'b1 : '0;
    bidx_d  = bidx_q;
    txsh_d  = txsh_q;
    rd_d    = rd_q;
    rxsh_d  = rxsh_q;
    rxv_d   = 1'b0;
    rxd_d   = rxd_q;
    case (state_q)
      ST_IDLE: begin
        if (tx_valid) begin
          state_d = ST_LEAD;
          per_d   = eff_per;
        end
      end
      ST_LEAD: begin
        if (lead_q == lead_len - 1'b1) begin
          state_d = ST_NEG;
          first_d = 1'b0;
        end
      end
      ST_NEG, ST_BITS: begin
        if (bit_end) begin
          if (state_q == ST_BITS) begin
            rxsh_d = {rxsh_q[BYTE_W-2:0], bit_val};
            if ((bidx_q == '0) && rd_q) begin
              rxv_d = 1'b1;
              rxd_d = {rxsh_q[BYTE_W-2:0], bit_val};
            end
          end
          if (last_slot) begin
            if (take) begin
              state_d = ST_BITS;
              txsh_d  = tx_data;
              rd_d    = tx_read;
              bidx_d  = BIW'(BYTE_W - 1);
            end else begin
              state_d = ST_STOP;
            end
          end else begin
            bidx_d = bidx_q - 1'b1;
            txsh_d = {txsh_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
      ST_STOP: begin
        if (stop_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      per_q   <= PMIN_V;
      first_q <= 1'b1;
      lead_q  <= '0;
      bidx_q  <= '0;
      txsh_q  <= '0;
      rd_q    <= 1'b0;
      rxsh_q  <= '0;
      rxv_q   <= 1'b0;
      rxd_q   <= '0;
    end else begin
      state_q <= state_d;
      per_q   <= per_d;
      first_q <= first_d;
      lead_q  <= lead_d;
      bidx_q  <= bidx_d;
      txsh_q  <= txsh_d;
      rd_q    <= rd_d;
      rxsh_q  <= rxsh_d;
      rxv_q   <= rxv_d;
      rxd_q   <= rxd_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> !bus_out); // R8
  AST_LEAD_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_LEAD) |-> !bus_out); // R3
  AST_PERIOD_LOCK: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && $past(busy)) |-> $stable(per_q)); // R4
  AST_RX_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_valid |-> $past(bit_end)); // R6
  AST_READY_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_sn)
    tx_ready |-> (busy && $past(bus_out == 1'b0 || run))); // R5
  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy) |-> (state_q == ST_LEAD)); // R7
endmodule

// File: tb/peci_bit_xcvr_bench.sv
`timescale 1ns/1ps
module peci_bit_xcvr_bench;
  localparam int PW = 18, PMIN = 8, PMAX = 64, FL = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] bit_period = PW'(20);
  logic tx_valid = 1'b0, tx_read = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, bus_out, busy, bus_in;
  logic [7:0] rx_data;
  logic cli = 1'b0;

  assign bus_in = bus_out | cli;

  always #2.5 clk = ~clk;

  peci_bit_xcvr #(.PW(PW), .PMIN(PMIN), .PMAX(PMAX), .FIRST_LEAD(FL)) u_peci_bit_xcvr (
    .clk(clk), .rst_n(rst_n), .bit_period(bit_period), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_read(tx_read), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .bus_in(bus_in),
    .bus_out(bus_out), .busy(busy));

  int vectors = 0, fails = 0;
  bit finished = 1'b0;

  // monitor state
  int cyc = 0, nr = 0, lead_cnt = 0, hcur = 0, cli_left = 0, nrx = 0;
  int poke_off = 0, poke_cyc = 0, fall_cyc = 0;
  bit poke_en = 1'b0, done_flag = 1'b0, busy_p = 1'b0, out_p = 1'b0;
  int rise_t [0:40];
  int got_hi [0:40];
  int exp_hi [0:40];
  int cli_len [0:40];
  logic [7:0] rx_got [0:7];
  logic [7:0] rx_exp [0:7];

  function automatic int clampp(input int v);
    if (v < PMIN) return PMIN;
    if (v > PMAX) return PMAX;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (busy && !busy_p) begin nr = 0; lead_cnt = 0; nrx = 0; end
    if (busy && nr == 0 && !bus_out) lead_cnt++;
    if (cli_left > 0) begin cli = 1'b1; cli_left--; end
    else cli = 1'b0;
    if (bus_out && !out_p) begin
      rise_t[nr] = cyc;
      hcur = 0;
      if (nr <= 40 && cli_len[nr] > 0) begin
        cli = 1'b1;
        cli_left = cli_len[nr] - 1;
      end
      nr++;
    end
    if (bus_out) hcur++;
    if (!bus_out && out_p && nr > 0) got_hi[nr-1] = hcur;
    if (poke_en && busy && nr > 0 && cyc == rise_t[nr-1] + poke_off) begin
      cli = 1'b1;
      poke_cyc = cyc;
    end
    if (rx_valid && nrx < 8) begin rx_got[nrx] = rx_data; nrx++; end
    if (!busy && busy_p) begin done_flag = 1'b1; fall_cyc = cyc; end
    busy_p = busy;
    out_p = bus_out;
  end

  // rdmode: 0 none read, 1 all read, 2 random
  task automatic run_msg(input int nb, input int cfg, input bit first,
                         input bit poke, input bit swap, input int rdmode);
    int p, ns, nexp, s, n;
    logic [7:0] dat [0:3];
    bit rd [0:3];
    p = clampp(cfg);
    ns = 1 + 8 * nb;
    nexp = 0;
    for (int i = 0; i <= 40; i++) cli_len[i] = 0;
    exp_hi[0] = p / 2;
    for (int b = 0; b < nb; b++) begin
      dat[b] = 8'($urandom);
      rd[b] = (rdmode == 1) || (rdmode == 2 && $urandom_range(0, 1) == 1);
      for (int k = 0; k < 8; k++) begin
        s = 1 + 8 * b + k;
        if (rd[b]) begin
          exp_hi[s] = p / 4;
          if (dat[b][7-k]) n = ($urandom_range(0, 1) == 1) ? p - p / 4 : p / 2 + 1;
          else             n = ($urandom_range(0, 1) == 1) ? 0 : p / 2;
          cli_len[s] = n;
        end else begin
          exp_hi[s] = dat[b][7-k] ? p - p / 4 : p / 4;
        end
      end
      if (rd[b]) begin rx_exp[nexp] = dat[b]; nexp++; end
    end
    poke_en = poke;
    poke_off = p + 5;
    done_flag = 1'b0;
    @(negedge clk);
    bit_period = PW'(cfg);
    if (nb == 0) begin
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
    end else begin
      tx_valid = 1'b1; tx_data = dat[0]; tx_read = rd[0];
      for (int b = 0; b < nb; b++) begin
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        @(posedge clk); #1;
        if (swap && b == 0) bit_period = PW'((cfg > 30) ? 10 : 50);
        if (b + 1 < nb) begin tx_data = dat[b+1]; tx_read = rd[b+1]; end
        else tx_valid = 1'b0;
      end
    end
    while (!done_flag) @(negedge clk);
    poke_en = 1'b0;
    chk(lead_cnt == (first ? FL : 2 * p), "R3 lead-in length", lead_cnt, first ? FL : 2 * p);
    chk(nr == ns, "R5 slot count", nr, ns);
    if (nr == ns) begin
      chk(got_hi[0] == exp_hi[0], "R2 negotiation high time", got_hi[0], exp_hi[0]);
      for (int i = 1; i < ns; i++)
        chk(got_hi[i] == exp_hi[i], "R1 data slot high time", got_hi[i], exp_hi[i]);
      for (int i = 1; i < ns; i++)
        chk(rise_t[i] - rise_t[i-1] == p, swap ? "R4 locked period" : "R1 slot period",
            rise_t[i] - rise_t[i-1], p);
      if (poke)
        chk(fall_cyc == poke_cyc + 2 * p + 1, "R7 stop restarted by rise",
            fall_cyc - rise_t[ns-1], poke_cyc + 2 * p + 1 - rise_t[ns-1]);
      else
        chk(fall_cyc - rise_t[ns-1] == 3 * p, "R7 stop tail", fall_cyc - rise_t[ns-1], 3 * p);
    end
    chk(nrx == nexp, "R6 read byte count", nrx, nexp);
    for (int i = 0; i < nexp && i < nrx; i++)
      chk(rx_got[i] == rx_exp[i], "R6 read byte value", int'(rx_got[i]), int'(rx_exp[i]));
    bit_period = PW'(cfg);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i <= 40; i++) cli_len[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_out && !busy && !tx_ready && !rx_valid, "R8 reset state",
        int'({bus_out, busy, tx_ready, rx_valid}), 0);

    run_msg(2, 20, 1'b1, 1'b0, 1'b0, 0);   // first message: long lead-in
    run_msg(3, 16, 1'b0, 1'b0, 1'b0, 1);   // all read bytes
    run_msg(0, 24, 1'b0, 1'b0, 1'b0, 0);   // negotiation only
    run_msg(2, 3, 1'b0, 1'b0, 1'b0, 2);    // clamp up to PMIN (R4)
    run_msg(1, 200, 1'b0, 1'b0, 1'b0, 2);  // clamp down to PMAX (R4)
    run_msg(2, 12, 1'b0, 1'b1, 1'b0, 2);   // rise during quiet window
    run_msg(3, 20, 1'b0, 1'b0, 1'b1, 2);   // period change mid-message

    // R8: abort mid-message
    @(negedge clk);
    bit_period = PW'(20);
    tx_valid = 1'b1; tx_data = 8'hA5; tx_read = 1'b0;
    repeat (100) @(negedge clk);
    chk(busy, "R8 busy before abort", int'(busy), 1);
    rst_n = 1'b0;
    #1;
    chk(!bus_out && !busy && !tx_ready && !rx_valid, "R8 abort outputs",
        int'({bus_out, busy, tx_ready, rx_valid}), 0);
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_out && !busy, "R8 idle after abort", int'({bus_out, busy}), 0);
    run_msg(1, 10, 1'b1, 1'b0, 1'b0, 2);

    for (int t = 0; t < 6; t++)
      run_msg($urandom_range(1, 4), $urandom_range(8, 64), 1'b0, 1'b0, 1'b0, 2);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule